// File: doc/BRIEF.md
# Dotclock Panel Timing Generator

This block produces the raster timing for an RGB panel that takes pixel data on a dot clock together with horizontal sync, vertical sync and a data-enable strobe. Two counters walk the frame, one in clocks across a line and one in lines down the frame. Every timing point is measured from the start of the sync pulse. The line and frame lengths, the sync widths and two wait counts mark the start of active video. Two valid counts then set how wide and how tall the active window is. The vertical settings are always counted in whole lines.

Each sync output and the data enable have their own polarity select. A sync-enable input gates both sync outputs without stopping the raster. The block also raises a pixel-request strobe one clock ahead of each data-enable clock, so that a pixel source has one cycle to present the pixel. The block also holds the frame base address. Software writes the next address at any time, and the block copies it into the current-address output only on the first clock of a frame. A run input starts the raster. When run is cleared, the raster finishes the frame in progress and then goes quiet.

Top module: `dotclk_timing`

## Requirements
- R1: After reset all outputs are at their inactive levels: each sync and data-enable pin sits at the complement of its polarity select, pixReq is 0, curBase is 0 and dotclkInvert is 0.
- R2: While running, a line lasts linePeriod clocks (counts 0 to linePeriod-1). The hsync pin is active on counts 0 to hsyncWidth-1 of every line, one clock after the counter holds that count.
- R3: The vsync pin is active for the whole of lines 0 to vsyncWidth-1 of each frame, which has framePeriod lines. The pin follows the counters by one clock.
- R4: The data-enable pin is active on line counts hWait to hWait+hValid-1 of lines vWait to vWait+vValid-1, and at no other time. The pin follows the counters by one clock.
- R5: pixReq is active high and is 1 in exactly the clock before each clock in which data enable is active.
- R6: A polarity select of 1 makes the matching pin (hsyncHigh, vsyncHigh, deHigh) active high. A select of 0 makes it active low. A change of select takes effect at the pin at once.
- R7: While syncEn is 0, both sync pins stay at their inactive levels, and data enable and pixReq carry on unchanged.
- R8: curBase takes the value of nextBase present on the first clock of each frame (line 0, count 0), one clock later. At all other times curBase holds its value.
- R9: With the raster idle, a run of 1 loads line 0, count 0 on the next edge, and the first hsync clock appears at the pin one edge after that.
- R10: When run is 0 at the last clock of a frame, the raster stops after completing that frame. Once idle, every pin is inactive and pixReq is 0 until run is set again.
- R11: dotclkInvert (1 = the panel samples on the falling dot clock edge) equals fallEdgeSel delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low reset |
| runEn | input | 1 | Run request |
| syncEn | input | 1 | Sync output enable |
| hsyncHigh | input | 1 | hsync active-high select |
| vsyncHigh | input | 1 | vsync active-high select |
| deHigh | input | 1 | Data enable active-high select |
| fallEdgeSel | input | 1 | Falling-edge sampling select |
| linePeriod | input | H_W | Clocks per line |
| hsyncWidth | input | H_W | hsync width in clocks |
| hWait | input | H_W | Clocks from line start to first active pixel |
| hValid | input | H_W | Active pixels per line |
| framePeriod | input | V_W | Lines per frame |
| vsyncWidth | input | V_W | vsync width in lines |
| vWait | input | V_W | Lines from frame start to first active line |
| vValid | input | V_W | Active lines per frame |
| nextBase | input | ADDR_W | Frame base address for the next frame |
| hsyncOut | output | 1 | Horizontal sync pin |
| vsyncOut | output | 1 | Vertical sync pin |
| deOut | output | 1 | Data enable pin |
| pixReq | output | 1 | Pixel request, one clock ahead of data enable |
| curBase | output | ADDR_W | Base address of the frame being scanned |
| dotclkInvert | output | 1 | Registered falling-edge select |

## Verification
pixReq depends only on the counter state, so it is due in the same cycle as that state. The sync pins, data enable, curBase and dotclkInvert are registered and are due one edge later, while the polarity selects act on the pins at once. The bench keeps its own model of the counters. At each falling edge it compares pixReq with the model's present state, compares the registered pins with the values it queued one cycle earlier, and then queues the values due after the next rising edge. The directed checks count edges from the stimulus in the same way: two edges from run to the first hsync, three edges after a mid-frame address write, and a full frame plus margin after run is cleared.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  // Strobes from the raster control to the output datapath
  typedef struct packed {
    logic run;         // raster counters are live
    logic hsAct;       // inside hsync window
    logic vsAct;       // inside vsync window
    logic deAct;       // inside active pixel window
    logic frameStart;  // line 0, count 0
  } tmgStrobe_t;
endpackage

// File: rtl/tmg_ctrl.sv
module tmg_ctrl
  import tmg_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic [H_W-1:0] linePeriod,
  input  logic [H_W-1:0] hsyncWidth,
  input  logic [H_W-1:0] hWait,
  input  logic [H_W-1:0] hValid,
  input  logic [V_W-1:0] framePeriod,
  input  logic [V_W-1:0] vsyncWidth,
  input  logic [V_W-1:0] vWait,
  input  logic [V_W-1:0] vValid,
  output tmgStrobe_t     stb
);
  localparam int HE_W = H_W + 1;
  localparam int VE_W = V_W + 1;

  logic           running;
  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic           lineEnd;
  logic           frameEnd;
  logic [HE_W-1:0] hStop;
  logic [VE_W-1:0] vStop;
  logic           inH;
  logic           inV;

  assign lineEnd  = (hCnt == linePeriod - 1'b1);
  assign frameEnd = lineEnd && (vCnt == framePeriod - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (!running) begin
      if (runEn) begin
        running <= 1'b1;
        hCnt    <= '0;
        vCnt    <= '0;
      end
    end else if (lineEnd) begin
      hCnt <= '0;
      if (frameEnd) begin
        vCnt    <= '0;
        running <= runEn;   // stop only on a frame boundary
      end else begin
        vCnt <= vCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // Window ends computed one bit wider so wait+valid cannot wrap
  assign hStop = {1'b0, hWait} + {1'b0, hValid};
  assign vStop = {1'b0, vWait} + {1'b0, vValid};
  assign inH   = (hCnt >= hWait) && ({1'b0, hCnt} < hStop);
  assign inV   = (vCnt >= vWait) && ({1'b0, vCnt} < vStop);

  always_comb begin
    stb.run        = running;
    stb.hsAct      = running && (hCnt < hsyncWidth);
    stb.vsAct      = running && (vCnt < vsyncWidth);
    stb.deAct      = running && inH && inV;
    stb.frameStart = running && (hCnt == '0) && (vCnt == '0);
  end
endmodule

// File: rtl/tmg_dpath.sv
module tmg_dpath
  import tmg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmgStrobe_t        stb,
  input  logic              syncEn,
  input  logic              fallEdgeSel,
  input  logic [ADDR_W-1:0] nextBase,
  output logic              hsQ,
  output logic              vsQ,
  output logic              deQ,
  output logic [ADDR_W-1:0] baseQ,
  output logic              invQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsQ   <= 1'b0;
      vsQ   <= 1'b0;
      deQ   <= 1'b0;
      baseQ <= '0;
      invQ  <= 1'b0;
    end else begin
      hsQ  <= syncEn && stb.hsAct;
      vsQ  <= syncEn && stb.vsAct;
      deQ  <= stb.deAct;
      invQ <= fallEdgeSel;
      if (stb.frameStart) baseQ <= nextBase;
    end
  end
endmodule

// File: rtl/dotclk_timing.sv
module dotclk_timing
  import tmg_pkg::*;
#(
  parameter int H_W    = 12,
  parameter int V_W    = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              syncEn,
  input  logic              hsyncHigh,
  input  logic              vsyncHigh,
  input  logic              deHigh,
  input  logic              fallEdgeSel,
  input  logic [H_W-1:0]    linePeriod,
  input  logic [H_W-1:0]    hsyncWidth,
  input  logic [H_W-1:0]    hWait,
  input  logic [H_W-1:0]    hValid,
  input  logic [V_W-1:0]    framePeriod,
  input  logic [V_W-1:0]    vsyncWidth,
  input  logic [V_W-1:0]    vWait,
  input  logic [V_W-1:0]    vValid,
  input  logic [ADDR_W-1:0] nextBase,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pixReq,
  output logic [ADDR_W-1:0] curBase,
  output logic              dotclkInvert
);
  tmgStrobe_t stb;
  logic hsQ, vsQ, deQ;

  tmg_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .linePeriod(linePeriod), .hsyncWidth(hsyncWidth),
    .hWait(hWait), .hValid(hValid),
    .framePeriod(framePeriod), .vsyncWidth(vsyncWidth),
    .vWait(vWait), .vValid(vValid),
    .stb(stb)
  );

  tmg_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .syncEn(syncEn),
    .fallEdgeSel(fallEdgeSel), .nextBase(nextBase),
    .hsQ(hsQ), .vsQ(vsQ), .deQ(deQ), .baseQ(curBase), .invQ(dotclkInvert)
  );

  // Polarity applied at the pin: active level equals the select bit
  assign hsyncOut = hsQ ? hsyncHigh : ~hsyncHigh;
  assign vsyncOut = vsQ ? vsyncHigh : ~vsyncHigh;
  assign deOut    = deQ ? deHigh    : ~deHigh;
  assign pixReq   = stb.deAct;
endmodule

// File: rtl/tmg_checker.sv
module tmg_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stbRun,
  input logic              stbFrameStart,
  input logic              pixReq,
  input logic              deQ,
  input logic              syncEn,
  input logic              hsyncOut,
  input logic              vsyncOut,
  input logic              hsyncHigh,
  input logic              vsyncHigh,
  input logic [ADDR_W-1:0] curBase,
  input logic [ADDR_W-1:0] nextBase
);
  p_req_leads_de_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> deQ);
  p_no_req_no_de_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pixReq |=> !deQ);
  p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> ((hsyncOut != hsyncHigh) && (vsyncOut != vsyncHigh)));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stbRun |-> !pixReq);
  p_base_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    stbFrameStart |=> (curBase == $past(nextBase)));
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stbFrameStart |=> $stable(curBase));
endmodule

bind dotclk_timing tmg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .stbRun(stb.run), .stbFrameStart(stb.frameStart),
  .pixReq(pixReq), .deQ(deQ), .syncEn(syncEn),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
  .hsyncHigh(hsyncHigh), .vsyncHigh(vsyncHigh),
  .curBase(curBase), .nextBase(nextBase)
);

// File: tb/dotclk_timing_test.sv
`timescale 1ns/1ps
module dotclk_timing_test;
  localparam int H_W = 12, V_W = 12, ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, syncEn = 1'b1;
  logic hsyncHigh = 1'b0, vsyncHigh = 1'b0, deHigh = 1'b0, fallEdgeSel = 1'b0;
  logic [H_W-1:0] linePeriod = 20, hsyncWidth = 3, hWait = 6, hValid = 10;
  logic [V_W-1:0] framePeriod = 12, vsyncWidth = 2, vWait = 4, vValid = 6;
  logic [ADDR_W-1:0] nextBase = 32'h1000_0000;
  logic hsyncOut, vsyncOut, deOut, pixReq, dotclkInvert;
  logic [ADDR_W-1:0] curBase;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dotclk_timing #(.H_W(H_W), .V_W(V_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .syncEn(syncEn),
    .hsyncHigh(hsyncHigh), .vsyncHigh(vsyncHigh), .deHigh(deHigh),
    .fallEdgeSel(fallEdgeSel),
    .linePeriod(linePeriod), .hsyncWidth(hsyncWidth), .hWait(hWait), .hValid(hValid),
    .framePeriod(framePeriod), .vsyncWidth(vsyncWidth), .vWait(vWait), .vValid(vValid),
    .nextBase(nextBase),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixReq(pixReq),
    .curBase(curBase), .dotclkInvert(dotclkInvert)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: expected registered outputs, queued one cycle ahead
  typedef struct packed {
    logic hs; logic vs; logic de; logic inv; logic [ADDR_W-1:0] base;
  } exp_t;
  exp_t expQ[$];

  bit mRun;
  int mH, mV;
  logic [ADDR_W-1:0] mBase;

  function automatic bit inWindow();
    return mRun && (mH >= int'(hWait)) && (mH < int'(hWait) + int'(hValid)) &&
           (mV >= int'(vWait)) && (mV < int'(vWait) + int'(vValid));
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      expQ.delete();
      mRun = 0; mH = 0; mV = 0; mBase = '0;
    end else if (!done) begin
      exp_t e;
      // monitor: compare against what was due at this point
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check(hsyncOut == (e.hs ? hsyncHigh : ~hsyncHigh), "R2 R6 hsync", hsyncOut, e.hs);
        check(vsyncOut == (e.vs ? vsyncHigh : ~vsyncHigh), "R3 R6 vsync", vsyncOut, e.vs);
        check(deOut == (e.de ? deHigh : ~deHigh), "R4 R6 de", deOut, e.de);
        check(curBase == e.base, "R8 curBase", curBase, e.base);
        check(dotclkInvert == e.inv, "R11 invert", dotclkInvert, e.inv);
      end
      check(pixReq == inWindow(), "R5 pixReq", pixReq, inWindow());
      // driver side: expectation after the next rising edge
      e.hs = mRun && syncEn && (mH < int'(hsyncWidth));
      e.vs = mRun && syncEn && (mV < int'(vsyncWidth));
      e.de = inWindow();
      e.inv = fallEdgeSel;
      if (mRun && mH == 0 && mV == 0) mBase = nextBase;
      e.base = mBase;
      expQ.push_back(e);
      // advance model counters
      if (!mRun) begin
        if (runEn) begin mRun = 1; mH = 0; mV = 0; end
      end else if (mH == int'(linePeriod) - 1) begin
        mH = 0;
        if (mV == int'(framePeriod) - 1) begin mV = 0; mRun = runEn; end
        else mV++;
      end else mH++;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R1: reset state with active-low selects
    check(hsyncOut == 1'b1, "R1 hsync idle", hsyncOut, 1);
    check(vsyncOut == 1'b1, "R1 vsync idle", vsyncOut, 1);
    check(deOut == 1'b1, "R1 de idle", deOut, 1);
    check(pixReq == 1'b0, "R1 pixReq idle", pixReq, 0);
    check(curBase == '0, "R1 curBase", curBase, 0);
    check(dotclkInvert == 1'b0, "R1 invert", dotclkInvert, 0);

    // R9: start, first hsync clock two edges after run
    runEn = 1'b1;
    waitCycles(2);
    check(hsyncOut == 1'b0, "R9 first hsync", hsyncOut, 0);
    waitCycles(100);
    // R8: mid-frame write does not move curBase
    nextBase = 32'h2000_0040;
    waitCycles(3);
    check(curBase == 32'h1000_0000, "R8 hold mid-frame", curBase, 32'h1000_0000);
    waitCycles(400);
    check(curBase == 32'h2000_0040, "R8 swap at frame", curBase, 32'h2000_0040);

    // R6: active-high selects, R11 falling edge select
    hsyncHigh = 1'b1; vsyncHigh = 1'b1; deHigh = 1'b1; fallEdgeSel = 1'b1;
    waitCycles(300);

    // R7: sync gated off, raster continues
    syncEn = 1'b0;
    begin
      bit seenSync = 0, seenDe = 0;
      for (int i = 0; i < 260; i++) begin
        waitCycles(1);
        if (hsyncOut == hsyncHigh || vsyncOut == vsyncHigh) seenSync = 1;
        if (deOut == deHigh) seenDe = 1;
      end
      check(!seenSync, "R7 sync held inactive", seenSync, 0);
      check(seenDe, "R7 de keeps running", seenDe, 1);
    end
    syncEn = 1'b1;
    hsyncHigh = 1'b0; deHigh = 1'b1;
    waitCycles(150);

    // R10: stop mid-frame, frame finishes, then idle
    runEn = 1'b0;
    waitCycles(300);
    check(pixReq == 1'b0, "R10 pixReq idle", pixReq, 0);
    check(deOut == ~deHigh, "R10 de idle", deOut, ~deHigh);
    check(hsyncOut == ~hsyncHigh, "R10 hsync idle", hsyncOut, ~hsyncHigh);
    check(vsyncOut == ~vsyncHigh, "R10 vsync idle", vsyncOut, ~vsyncHigh);

    // New timing while idle, restart (R2 R3 R4 R9 under another pattern)
    linePeriod = 16; hsyncWidth = 1; hWait = 3; hValid = 13;
    framePeriod = 9; vsyncWidth = 3; vWait = 3; vValid = 6;
    nextBase = 32'h3000_0000;
    waitCycles(5);
    runEn = 1'b1;
    waitCycles(2);
    check(hsyncOut == hsyncHigh, "R9 restart hsync", hsyncOut, hsyncHigh);
    check(curBase == 32'h3000_0000, "R8 restart base", curBase, 32'h3000_0000);
    waitCycles(350);
    runEn = 1'b0;
    waitCycles(200);
    check(pixReq == 1'b0, "R10 stopped again", pixReq, 0);
    finishRun();
  end
endmodule